// File: doc/BRIEF.md
# Debug Address Watchpoint Comparator

This block holds four address-compare slots that watch the stream of bus accesses issued by a core. Every clock cycle it may receive one access, made of an address, a size code and a kind (instruction fetch, data read or data write), and compares it in parallel against each slot. A slot only takes part when it is enabled. Its access-type code decides which kinds of access it cares about, and its length code gives the size of its naturally aligned watch region. Slots that match set sticky bits in a status register, and a one-cycle trap flag reports that some slot fired.

Software reaches the slot addresses, the packed control word and the status word through a simple select, write and read port. A single task-switch pulse drops the per-task (local) enables and leaves the global ones in place. The control word has a fixed layout:

- bits 0 to 7 carry two enable bits per slot;
- bits 8 and 9 are two stored flags;
- bits 10 to 15 are held at zero;
- bits 16 to 31 carry one 4-bit type-and-length nibble per slot.

Top module: `dbg_watch_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, every slot is vacant and trap_o is 0.
- R2: A control write stores the word with bits 15:10 forced to zero, so those bits always read zero; bits 8 and 9 and all other bits are stored and read back as written.
- R3: Slot i has a local enable at control bit 2*i and a global enable at bit 2*i+1. It can match only when at least one of the two is set.
- R4: Slot i's nibble sits at control bits 16+4*i to 19+4*i, and its low two bits give the access type. 00 matches fetches, 01 matches data writes only, 11 matches data reads and data writes, and 10 never matches.
- R5: The nibble's upper two bits give the length: 00 means 1 byte, 01 means 2, 11 means 4 and 10 means 8. The region is the slot address with its low log2(length) bits cleared, extended by the length.
- R6: A data access counts only while acc_valid is 1. It covers the bytes from acc_addr to acc_addr+2^acc_size-1, where acc_kind is 00 fetch, 01 read and 10 write, and 11 is no access. It matches a data slot when this byte range overlaps the slot region.
- R7: A fetch-type slot matches a fetch only when acc_addr equals the slot address exactly, whatever its length code and acc_size hold.
- R8: Status bit i (i < 4) is set when slot i matches and stays set until software writes 0 to it. Writing 1 leaves the bit unchanged, a match in the same cycle as a clearing write wins, and status bits 31:4 read zero.
- R9: A task_switch pulse clears every local enable bit and leaves every global enable bit unchanged. When it coincides with a control write, the clearing applies to the written value.
- R10: trap_o is 1 in the cycle after an access that matched any slot, and 0 otherwise.
- R11: reg_sel 0 to 3 selects the slot address registers, 4 selects control and 5 selects status. Selects 6 and 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 none |
| acc_size | input | 2 | log2 of the access size in bytes |
| acc_addr | input | AW | Access start address |
| task_switch | input | 1 | Pulse that drops the local enables |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_sel (combinational) |
| trap_o | output | 1 | Some slot matched the previous access |

## Verification
The checker watches, on every cycle, the invariants that depend only on state. These cover the reserved control bits staying zero, local enables vanishing after a task switch while global ones hold, status bits never dropping without a status write, status bits 31:4 reading zero, and a trap always coming from a valid access against at least one enabled slot with status set. The actual comparison is visible only through the bench scenarios, which track a model of the registers. These scenarios cover:

- the non-monotonic length coding and region alignment;
- the overlap at region edges;
- exact-address fetch matching;
- the never-matching I/O type;
- a clear write colliding with a hit.

// File: rtl/dbgw_pkg.sv
// Package: shared constants, access kinds and length decoding for the
// watchpoint comparator. Assumes a 32-bit control word holding four slots.
package dbgw_pkg;

    localparam int NSLOT = 4;
    localparam int CW    = 32;
    localparam int NIB_BASE = 16;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_NONE  = 2'b11
    } acc_kind_e;

    localparam logic [1:0] TY_FETCH = 2'b00;
    localparam logic [1:0] TY_WR    = 2'b01;
    localparam logic [1:0] TY_IO    = 2'b10;
    localparam logic [1:0] TY_RW    = 2'b11;

    localparam logic [2:0] SEL_CTRL = 3'd4;
    localparam logic [2:0] SEL_STAT = 3'd5;

    localparam logic [CW-1:0] RSVD_MASK = 32'h0000_FC00;

    // Map the non-monotonic length code onto log2 of the byte count.
    function automatic logic [1:0] len_log2(input logic [1:0] code);
        case (code)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // Mask of the local enable bits (even positions of the enable field).
    function automatic logic [CW-1:0] local_mask();
        logic [CW-1:0] m;
        m = '0;
        for (int i = 0; i < NSLOT; i++) m[2*i] = 1'b1;
        return m;
    endfunction

    // Mask of the global enable bits (odd positions of the enable field).
    function automatic logic [CW-1:0] global_mask();
        logic [CW-1:0] m;
        m = '0;
        for (int i = 0; i < NSLOT; i++) m[2*i+1] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dbgw_ctrl_reg.sv
// Control word register. Applies the reserved-bit mask on every write and
// clears the local enables on a task-switch pulse, after any write that
// lands in the same cycle. Assumes a synchronous active-low reset.
module dbgw_ctrl_reg
    import dbgw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wdata,
    input  logic          task_sw,
    output logic [CW-1:0] ctrl_q
);

    localparam logic [CW-1:0] LOC_M = local_mask();

    logic [CW-1:0] ctrl_d;

    // Next value: masked write first, then local-enable clearing.
    always_comb begin
        ctrl_d = wr_en ? (wdata & ~RSVD_MASK) : ctrl_q;
        if (task_sw) ctrl_d = ctrl_d & ~LOC_M;
    end

    // State update.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

endmodule

// File: rtl/dbgw_addr_bank.sv
// Bank of slot address registers, one written per cycle by index.
// Assumes the index is valid whenever wr_en is high.
module dbgw_addr_bank
    import dbgw_pkg::*;
#(
    parameter int AW = 32,
    localparam int IW = $clog2(NSLOT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IW-1:0]             wr_idx,
    input  logic [AW-1:0]             wdata,
    output logic [NSLOT-1:0][AW-1:0]  addr_q
);

    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_slot
            // One address register per slot.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    addr_q[g] <= '0;
                else if (wr_en && wr_idx == IW'(g))
                    addr_q[g] <= wdata;
            end
        end
    endgenerate

endmodule

// File: rtl/dbgw_slot_cmp.sv
// Combinational compare of one access against one slot. Data slots use a
// byte-range overlap against the aligned region; fetch slots use exact
// address equality. Widths are extended by one bit so no sum wraps.
module dbgw_slot_cmp
    import dbgw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] slot_addr,
    input  logic [1:0]    enable,
    input  logic [3:0]    nibble,
    input  logic          acc_valid,
    input  logic [1:0]    acc_kind,
    input  logic [1:0]    acc_size,
    input  logic [AW-1:0] acc_addr,
    output logic          hit
);

    acc_kind_e     kind;
    logic [1:0]    lg;
    logic [AW:0]   s_span, s_lo, s_hi;
    logic [AW:0]   a_span, a_lo, a_hi;
    logic          overlap;

    // Region and access byte ranges.
    always_comb begin
        kind    = acc_kind_e'(acc_kind);
        lg      = len_log2(nibble[3:2]);
        s_span  = ((AW+1)'(1) << lg) - (AW+1)'(1);
        s_lo    = {1'b0, slot_addr} & ~s_span;
        s_hi    = s_lo + s_span;
        a_span  = ((AW+1)'(1) << acc_size) - (AW+1)'(1);
        a_lo    = {1'b0, acc_addr};
        a_hi    = a_lo + a_span;
        overlap = (a_lo <= s_hi) && (s_lo <= a_hi);
    end

    // Type decode and final qualification.
    always_comb begin
        hit = 1'b0;
        if (acc_valid && (enable != 2'b00)) begin
            case (nibble[1:0])
                TY_FETCH: hit = (kind == ACC_FETCH) && (acc_addr == slot_addr);
                TY_WR:    hit = (kind == ACC_WRITE) && overlap;
                TY_RW:    hit = ((kind == ACC_READ) || (kind == ACC_WRITE)) && overlap;
                default:  hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/dbgw_status_reg.sv
// Sticky hit register. A status write clears bits written as zero; a hit in
// the same cycle sets its bit regardless.
module dbgw_status_reg
    import dbgw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [NSLOT-1:0] wdata,
    input  logic [NSLOT-1:0] hits,
    output logic [NSLOT-1:0] stat_q
);

    // Clear-by-zero write, then OR in this cycle's hits.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (wr_en ? (stat_q & wdata) : stat_q) | hits;
    end

endmodule

// File: rtl/dbg_watch_unit.sv
// Top of the watchpoint comparator: four slots, packed control word, sticky
// status, register port and a registered trap flag. Assumes AW <= 32 and a
// synchronous active-low reset.
module dbg_watch_unit
    import dbgw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [1:0]    acc_kind,
    input  logic [1:0]    acc_size,
    input  logic [AW-1:0] acc_addr,
    input  logic          task_switch,
    input  logic          reg_wr,
    input  logic [2:0]    reg_sel,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] reg_rdata,
    output logic          trap_o
);

    localparam int IW = $clog2(NSLOT);

    logic [NSLOT-1:0][AW-1:0] addr_q;
    logic [CW-1:0]            ctrl_q;
    logic [NSLOT-1:0]         stat_q;
    logic [NSLOT-1:0]         hits;
    logic                     wr_addr, wr_ctrl, wr_stat;

    // Register write decode.
    always_comb begin
        wr_addr = reg_wr && (reg_sel[2] == 1'b0);
        wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
        wr_stat = reg_wr && (reg_sel == SEL_STAT);
    end

    dbgw_addr_bank #(.AW(AW)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_addr),
        .wr_idx (reg_sel[IW-1:0]),
        .wdata  (reg_wdata[AW-1:0]),
        .addr_q (addr_q)
    );

    dbgw_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ctrl),
        .wdata   (reg_wdata),
        .task_sw (task_switch),
        .ctrl_q  (ctrl_q)
    );

    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_cmp
            dbgw_slot_cmp #(.AW(AW)) u_cmp (
                .slot_addr (addr_q[g]),
                .enable    (ctrl_q[2*g +: 2]),
                .nibble    (ctrl_q[NIB_BASE + 4*g +: 4]),
                .acc_valid (acc_valid),
                .acc_kind  (acc_kind),
                .acc_size  (acc_size),
                .acc_addr  (acc_addr),
                .hit       (hits[g])
            );
        end
    endgenerate

    dbgw_status_reg u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_stat),
        .wdata  (reg_wdata[NSLOT-1:0]),
        .hits   (hits),
        .stat_q (stat_q)
    );

    // Registered trap flag: any slot matched the current access.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_o <= 1'b0;
        else        trap_o <= |hits;
    end

    // Read mux by select.
    always_comb begin
        reg_rdata = '0;
        if (reg_sel[2] == 1'b0)
            reg_rdata = CW'(addr_q[reg_sel[IW-1:0]]);
        else if (reg_sel == SEL_CTRL)
            reg_rdata = ctrl_q;
        else if (reg_sel == SEL_STAT)
            reg_rdata = CW'(stat_q);
    end

endmodule

// File: rtl/dbgw_watch_chk.sv
// Checker for dbg_watch_unit: state invariants of control, status and trap.
module dbgw_watch_chk
    import dbgw_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             task_switch,
    input logic             reg_wr,
    input logic [2:0]       reg_sel,
    input logic [CW-1:0]    reg_rdata,
    input logic [CW-1:0]    ctrl_q,
    input logic [NSLOT-1:0] stat_q,
    input logic             trap_o
);

    localparam logic [CW-1:0] LOC_M = local_mask();
    localparam logic [CW-1:0] GLB_M = global_mask();
    localparam logic [CW-1:0] EN_M  = LOC_M | GLB_M;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & RSVD_MASK) == '0); // R2

    AST_LOCAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        task_switch |=> (ctrl_q & LOC_M) == '0); // R9

    AST_GLOBAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        task_switch && !(reg_wr && reg_sel == SEL_CTRL)
        |=> (ctrl_q & GLB_M) == ($past(ctrl_q) & GLB_M)); // R9

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_sel == SEL_STAT)
        |=> (stat_q & $past(stat_q)) == $past(stat_q)); // R8

    AST_STAT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_STAT) |-> reg_rdata[CW-1:NSLOT] == '0); // R8

    AST_TRAP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $past(acc_valid) && (($past(ctrl_q) & EN_M) != '0)); // R3

    AST_TRAP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> stat_q != '0); // R10

endmodule

bind dbg_watch_unit dbgw_watch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .task_switch (task_switch),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_rdata   (reg_rdata),
    .ctrl_q      (ctrl_q),
    .stat_q      (stat_q),
    .trap_o      (trap_o)
);

// File: tb/sim_dbg_watch_unit.sv
module sim_dbg_watch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = 2'b11;
    logic [1:0]  acc_size = 2'b00;
    logic [31:0] acc_addr = '0;
    logic        task_switch = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        trap_o;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model of the software-visible state.
    logic [31:0] m_addr [4];
    logic [31:0] m_ctrl;
    logic [3:0]  m_stat;

    always #10 clk = ~clk;

    dbg_watch_unit #(.AW(32)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_size(acc_size), .acc_addr(acc_addr), .task_switch(task_switch),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .trap_o(trap_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit m_hit(int i, bit v, logic [1:0] k, longint unsigned a, int sz);
        logic [1:0] en, ty, lc;
        longint unsigned bytes, base, ab;
        en = m_ctrl[2*i +: 2];
        ty = m_ctrl[16+4*i +: 2];
        lc = m_ctrl[18+4*i +: 2];
        bytes = (lc == 2'b00) ? 1 : (lc == 2'b01) ? 2 : (lc == 2'b11) ? 4 : 8;
        base = longint'(m_addr[i]) - (longint'(m_addr[i]) % bytes);
        ab = longint'(1) << sz;
        if (!v || en == 2'b00) return 1'b0;
        case (ty)
            2'b00: return (k == 2'b00) && (a == longint'(m_addr[i]));
            2'b01: return (k == 2'b10) && (a < base + bytes) && (base < a + ab);
            2'b11: return (k == 2'b01 || k == 2'b10) && (a < base + bytes) && (base < a + ab);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] m_read(logic [2:0] s);
        if (s < 4) return m_addr[s[1:0]];
        if (s == 3'd4) return m_ctrl;
        if (s == 3'd5) return {28'd0, m_stat};
        return 32'd0;
    endfunction

    // One clock: drive at falling edge, update model at rising edge, check trap (R10).
    task automatic cyc(bit v, logic [1:0] k, logic [31:0] a, logic [1:0] sz, bit ts,
                       bit wr, logic [2:0] sel, logic [31:0] wd);
        logic [3:0] h;
        @(negedge clk);
        acc_valid = v; acc_kind = k; acc_addr = a; acc_size = sz;
        task_switch = ts; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        for (int i = 0; i < 4; i++) h[i] = m_hit(i, v, k, longint'(a), int'(sz));
        @(posedge clk);
        if (wr && sel < 4) m_addr[sel[1:0]] = wd;
        if (wr && sel == 3'd4) m_ctrl = wd & ~32'h0000_FC00;
        if (ts) m_ctrl = m_ctrl & ~32'h0000_0055;
        m_stat = ((wr && sel == 3'd5) ? (m_stat & wd[3:0]) : m_stat) | h;
        #1;
        chk({31'd0, trap_o}, {31'd0, |h}, "R10 trap");
        acc_valid = 1'b0; reg_wr = 1'b0; task_switch = 1'b0;
    endtask

    task automatic wreg(logic [2:0] sel, logic [31:0] wd);
        cyc(0, 2'b11, 32'd0, 2'd0, 0, 1, sel, wd);
    endtask

    task automatic acc(logic [1:0] k, logic [31:0] a, logic [1:0] sz);
        cyc(1, k, a, sz, 0, 0, 3'd0, 32'd0);
    endtask

    task automatic rreg(logic [2:0] sel, input string tag);
        reg_sel = sel;
        #1;
        chk(reg_rdata, m_read(sel), tag);
    endtask

    // Watchdog.
    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) m_addr[i] = '0;
        m_ctrl = '0; m_stat = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        for (int s = 0; s < 8; s++) rreg(3'(s), "R1 reset read");
        chk({31'd0, trap_o}, 32'd0, "R1 trap");

        // R2 reserved mask, slowdown flags kept
        wreg(3'd4, 32'hFFFF_FFFF);
        rreg(3'd4, "R2 ctrl mask");
        chk(reg_rdata, 32'hFFFF_03FF, "R2 literal");
        wreg(3'd4, 32'h0000_0000);

        // R5/R6 slot0 write-only, 4-byte region at 0x1000
        wreg(3'd0, 32'h0000_1002);
        wreg(3'd4, 32'h000D_0001);
        acc(2'b10, 32'h0000_1000, 2'd0);   // R5 aligned region hit
        acc(2'b01, 32'h0000_1001, 2'd0);   // R4 read ignored by write-only
        acc(2'b10, 32'h0000_0FFC, 2'd2);   // R6 ends below region
        acc(2'b10, 32'h0000_0FFE, 2'd2);   // R6 overlaps low edge
        acc(2'b10, 32'h0000_1004, 2'd0);   // R6 just past region
        rreg(3'd5, "R8 status after hits");
        chk(reg_rdata, 32'd1, "R8 literal");

        // R8 clear by zero, write one no effect
        wreg(3'd5, 32'hFFFF_FFFE);
        rreg(3'd5, "R8 clear");
        wreg(3'd5, 32'hFFFF_FFFF);
        rreg(3'd5, "R8 write one");
        chk(reg_rdata, 32'd0, "R8 literal zero");

        // R8 hit wins over simultaneous clear
        cyc(1, 2'b10, 32'h0000_1003, 2'd0, 0, 1, 3'd5, 32'd0);
        rreg(3'd5, "R8 hit wins");
        chk(reg_rdata, 32'd1, "R8 literal hit wins");
        wreg(3'd5, 32'd0);

        // R3 vacant slot never matches
        wreg(3'd4, 32'h000D_0000);
        acc(2'b10, 32'h0000_1000, 2'd0);
        rreg(3'd5, "R3 vacant");

        // R7 fetch slot exact match, global enable, 8-byte length ignored
        wreg(3'd1, 32'h0000_2003);
        wreg(3'd4, 32'h0080_0008);
        acc(2'b00, 32'h0000_2003, 2'd3);   // R7 exact
        acc(2'b00, 32'h0000_2000, 2'd3);   // R7 same region, not exact
        acc(2'b10, 32'h0000_2003, 2'd0);   // R4 write on fetch slot
        rreg(3'd5, "R7 status");
        wreg(3'd5, 32'd0);

        // R4 I/O type never matches
        wreg(3'd4, 32'h0002_0003);
        acc(2'b10, 32'h0000_1002, 2'd0);
        acc(2'b01, 32'h0000_1002, 2'd0);

        // R9 task switch drops local, keeps global
        wreg(3'd4, 32'h00DD_030B);
        cyc(0, 2'b11, 32'd0, 2'd0, 1, 0, 3'd0, 32'd0);
        rreg(3'd4, "R9 after pulse");
        chk(reg_rdata, 32'h00DD_030A, "R9 literal");
        cyc(0, 2'b11, 32'd0, 2'd0, 1, 1, 3'd4, 32'h000D_0003);
        rreg(3'd4, "R9 write with pulse");

        // R11 unused selects
        wreg(3'd6, 32'hDEAD_BEEF);
        wreg(3'd7, 32'h1234_5678);
        rreg(3'd6, "R11 sel6");
        rreg(3'd7, "R11 sel7");
        for (int s = 0; s < 6; s++) rreg(3'(s), "R11 map");

        // Random mix over a small address window
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom_range(0, 19));
            if (r == 0)
                wreg(3'd4, $urandom);
            else if (r == 1)
                wreg(3'($urandom_range(0, 3)), 32'h100 + $urandom_range(0, 63));
            else if (r == 2)
                wreg(3'd5, $urandom);
            else if (r == 3)
                cyc(1, 2'($urandom_range(0, 3)), 32'h100 + $urandom_range(0, 63),
                    2'($urandom_range(0, 3)), 1, 0, 3'd0, 32'd0);
            else
                acc(2'($urandom_range(0, 3)), 32'h100 + $urandom_range(0, 63),
                    2'($urandom_range(0, 3)));
            if (n % 8 == 0) rreg(3'($urandom_range(0, 7)), "R6 random read");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule